// File: doc/BRIEF.md
# Nine-bit serial command writer for display controllers

This block sends register writes to a display controller over a write-only serial bus whose words are nine bits wide. Every word starts with a flag bit that tells the controller whether the remaining eight bits are a command or a data byte. A request names a register address, a payload length of zero, one or two bytes, and a 16-bit payload value. The block turns the request into one framed burst of one to three words under a single chip-select assertion. It then signals completion with a one-cycle pulse.

The serial clock idles high. The controller samples data on the rising edge, and the block moves MOSI only on falling edges. The serial clock rate comes from a per-request half-period setting given in system clock cycles. A new request waits behind the handshake while a burst is in flight and is never lost.

Top module: `spi9_cmd_writer`

## Requirements
- R1: Every word is 9 bits long and is sent most significant bit first. Bit 8 is the flag: 0 marks the command word and 1 marks a data word. Bits 7:0 carry the byte.
- R2: The frame holds the command word carrying `req_addr_i`, followed by `req_len_i` data words. `req_len_i` of 0, 1 and 2 gives 9, 18 and 27 bits. A value of 3 behaves as 2.
- R3: With two data words, the first carries `req_data_i[15:8]` and the second carries `req_data_i[7:0]`. A single data word carries `req_data_i[7:0]`.
- R4: `sck_o` is high whenever `cs_no` is high. `mosi_o` changes only in a cycle where `sck_o` has just fallen.
- R5: Inside a frame, consecutive rising edges of `sck_o` are exactly 2*max(`half_div_i`,1) system cycles apart. `half_div_i` is taken when the request is accepted.
- R6: `cs_no` falls once per request and stays low until the last bit has been sampled. Between two frames it stays high for at least 2*max(`half_div_i`,1) system cycles.
- R7: `req_ready_o` is low from acceptance until `done_o`. `done_o` is high for exactly one cycle, in a cycle where `cs_no` and `req_ready_o` are both high.
- R8: A request is accepted only on a cycle with `req_valid_i` and `req_ready_o` both high. A request held valid during a busy period is sent after the current one, exactly once. Request inputs that change after acceptance do not alter the frame in flight.
- R9: While `rst_ni` is low, the outputs are `cs_no`=1, `sck_o`=1, `mosi_o`=0, `req_ready_o`=1 and `done_o`=0, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_div_i | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 8 | Register address for the command word |
| req_len_i | input | 2 | Number of payload bytes |
| req_data_i | input | 16 | Payload value |
| sck_o | output | 1 | Serial clock, idles high |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The main function is driven with command-only frames, one-byte frames and two-byte frames. It is also driven with the out-of-range length code. This separates word-count errors from byte-order errors, since the two-byte cases use unequal high and low bytes. Payloads of all ones, all zeros and mixed bits show whether the flag bit is kept apart from the byte. Different half-period settings, including zero, check clock timing and the gap between frames. A request held valid through a busy period, and inputs scrambled after acceptance, show that requests are neither dropped nor resampled. A reset in the middle of a frame confirms the return to idle.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int MAX_WORDS = 3;
  localparam int DATA_W    = BYTE_W * (MAX_WORDS - 1);
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int LEN_W     = $clog2(MAX_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_GAP1, ST_GAP2
  } st_e;
endpackage

// File: rtl/spi9_frame_pack.sv
module spi9_frame_pack
  import spi9_pkg::*;
(
  input  logic [BYTE_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    if (int'(len_i) > MAX_WORDS - 1) eff_len = LEN_W'(MAX_WORDS - 1);
    else                             eff_len = len_i;
  end

  assign frame_o[FRAME_W-1 -: WORD_W] = {1'b0, addr_i};
  assign nbits_o = CNT_W'(WORD_W * (int'(eff_len) + 1));

  // data slot k carries byte (eff_len-k): high byte first
  for (genvar k = 1; k < MAX_WORDS; k++) begin : g_slot
    logic [DATA_W-1:0] shifted;
    logic [WORD_W-1:0] word;
    always_comb begin
      shifted = '0;
      word    = '0;
      if (k <= int'(eff_len)) begin
        shifted = data_i >> (BYTE_W * (int'(eff_len) - k));
        word    = {1'b1, shifted[BYTE_W-1:0]};
      end
    end
    assign frame_o[FRAME_W-1-k*WORD_W -: WORD_W] = word;
  end
endmodule

// File: rtl/spi9_tick_gen.sv
module spi9_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/spi9_shift_out.sv
module spi9_shift_out
  import spi9_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               empty_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   rem_q;

  assign bit_o   = sh_q[FRAME_W-1];
  assign empty_o = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      rem_q <= nbits_i;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      rem_q <= rem_q - 1'b1;
    end
  end

  p_no_underrun_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !empty_o);
  p_load_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o);
endmodule

// File: rtl/spi9_cmd_writer.sv
module spi9_cmd_writer
  import spi9_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_addr_i,
  input  logic [1:0]        req_len_i,
  input  logic [15:0]       req_data_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              done_o
);
  st_e              st_q;
  logic [DIV_W-1:0] half_q;
  logic             sck_q, cs_nq, mosi_q, done_q;
  logic             accept, tick, shift, sh_bit, sh_empty;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign shift       = tick && ((st_q == ST_LEAD) || (st_q == ST_HIGH && !sh_empty));

  spi9_frame_pack u_pack (
    .addr_i  (req_addr_i),
    .len_i   (req_len_i),
    .data_i  (req_data_i),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  spi9_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .half_i (half_q),
    .tick_o (tick)
  );

  spi9_shift_out u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .frame_i (frame),
    .nbits_i (nbits),
    .shift_i (shift),
    .bit_o   (sh_bit),
    .empty_o (sh_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_q <= DIV_W'(1);
      sck_q  <= 1'b1;
      cs_nq  <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          half_q <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
          cs_nq  <= 1'b0;
          st_q   <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sck_q  <= 1'b0;
          mosi_q <= sh_bit;
          st_q   <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sck_q <= 1'b1;
          st_q  <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (sh_empty) begin
            cs_nq <= 1'b1;
            st_q  <= ST_GAP1;
          end else begin
            sck_q  <= 1'b0;
            mosi_q <= sh_bit;
            st_q   <= ST_LOW;
          end
        end
        ST_GAP1: if (tick) st_q <= ST_GAP2;
        ST_GAP2: if (tick) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign cs_no  = cs_nq;
  assign mosi_o = mosi_q;
  assign done_o = done_q;

  p_sck_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sck_o);
  p_mosi_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> $fell(sck_o));
  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && req_ready_o));
  p_frame_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> sh_empty);
  p_cs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
endmodule

// File: tb/tb_spi9_cmd_writer.sv
module tb_spi9_cmd_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [7:0]  div;
    logic [7:0]  addr;
    logic [1:0]  len;
    logic [15:0] data;
    logic [4:0]  nb;
    logic [26:0] frame;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd1, 8'h29, 2'd0, 16'h0000, 5'd9,  {9'h029, 18'h0}},
    '{8'd2, 8'hbc, 2'd1, 16'h1280, 5'd18, {9'h0bc, 9'h180, 9'h000}},
    '{8'd3, 8'hb8, 2'd2, 16'hfff9, 5'd27, {9'h0b8, 9'h1ff, 9'h1f9}},
    '{8'd0, 8'hc3, 2'd2, 16'h2040, 5'd27, {9'h0c3, 9'h120, 9'h140}},
    '{8'd2, 8'h3a, 2'd3, 16'ha560, 5'd27, {9'h03a, 9'h1a5, 9'h160}},
    '{8'd4, 8'h00, 2'd1, 16'h00ff, 5'd18, {9'h000, 9'h1ff, 9'h000}},
    '{8'd1, 8'hff, 2'd2, 16'h0000, 5'd27, {9'h0ff, 9'h100, 9'h100}}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] half_div = 8'd1;
  logic req_valid = 0, req_ready;
  logic [7:0] req_addr = 0;
  logic [1:0] req_len = 0;
  logic [15:0] req_data = 0;
  logic sck, cs_n, mosi, done;

  spi9_cmd_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_data_i(req_data),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, exp_half = 1, gap_half = 0;
  int nb = 0, frames = 0, last_nb = 0, cs_falls = 0;
  int last_rise = -1, cs_rise_cyc = -1;
  int per_err = 0, mosi_err = 0, idle_err = 0, gap_err = 0, rdy_err = 0;
  logic [26:0] cap = 0, last_frame = 0;
  logic psck = 1, pcs = 1, pmosi = 0;

  always @(negedge clk) begin
    cyc++;
    if (sck && !psck && !cs_n) begin
      cap = {cap[25:0], mosi};
      nb++;
      if (last_rise >= 0 && (cyc - last_rise) != 2 * exp_half) per_err++;
      last_rise = cyc;
    end
    if (mosi !== pmosi && !(psck && !sck)) mosi_err++;
    if (cs_n && !sck) idle_err++;
    if (!cs_n && req_ready) rdy_err++;
    if (!cs_n && pcs) begin
      cs_falls++;
      if (cs_rise_cyc >= 0 && (cyc - cs_rise_cyc) < 2 * gap_half) gap_err++;
      nb = 0; cap = 0; last_rise = -1;
    end
    if (cs_n && !pcs) begin
      cs_rise_cyc = cyc;
      gap_half = exp_half;
      last_frame = cap;
      last_nb = nb;
      frames++;
    end
    psck = sck; pcs = cs_n; pmosi = mosi;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_err();
    per_err = 0; mosi_err = 0; idle_err = 0; gap_err = 0; rdy_err = 0; cs_falls = 0;
  endtask

  task automatic issue(input logic [7:0] d, input logic [7:0] a,
                       input logic [1:0] l, input logic [15:0] v, input bit keep);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    half_div = d; req_addr = a; req_len = l; req_data = v; req_valid = 1;
    exp_half = (d == 0) ? 1 : int'(d);
    if (!keep) begin
      @(negedge clk);
      req_valid = 0;
      req_addr = ~a; req_len = ~l; req_data = ~v; half_div = d + 8'd5;
    end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  function automatic logic [26:0] just(input logic [26:0] c, input int n);
    return c << (27 - n);
  endfunction

  initial begin
    #(3 * CLK_PERIOD + 1);
    // R9 reset state
    chk(cs_n == 1 && sck == 1 && mosi == 0 && req_ready == 1 && done == 0,
        "R9", "reset outputs", {cs_n, sck, mosi, req_ready, done}, 5'b11010);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      clr_err();
      issue(VECS[i].div, VECS[i].addr, VECS[i].len, VECS[i].data, 0);
      wait_done();
      chk(req_ready && cs_n, "R7", "ready/cs at done", {req_ready, cs_n}, 2'b11);
      chk(last_nb == int'(VECS[i].nb), "R2", "bit count", last_nb, VECS[i].nb);
      chk(just(last_frame, last_nb) == VECS[i].frame, "R1 R3 R8", "frame bits",
          just(last_frame, last_nb), VECS[i].frame);
      chk(per_err == 0, "R5", "sck period", per_err, 0);
      chk(mosi_err == 0 && idle_err == 0, "R4", "edge/idle", mosi_err + idle_err, 0);
      chk(cs_falls == 1 && gap_err == 0, "R6", "cs framing", {cs_falls, gap_err}, 1 << 32'd0);
      chk(rdy_err == 0, "R7", "ready while busy", rdy_err, 0);
      @(negedge clk);
      chk(done == 0, "R7", "done width", done, 0);
    end

    // R8: request held valid while busy is sent after, exactly once
    clr_err();
    begin
      int f0;
      f0 = frames;
      issue(8'd2, 8'h11, 2'd1, 16'h0042, 0);
      @(negedge clk);
      half_div = 8'd2; req_addr = 8'h28; req_len = 2'd0; req_data = 16'h0; req_valid = 1;
      wait_done();
      chk(just(last_frame, last_nb) == {9'h011, 9'h142, 9'h0}, "R8", "first frame",
          just(last_frame, last_nb), {9'h011, 9'h142, 9'h0});
      @(negedge clk);
      req_valid = 0;
      wait_done();
      chk(last_nb == 9 && last_frame[8:0] == 9'h028, "R8", "held frame",
          last_frame[8:0], 9'h028);
      chk(frames - f0 == 2, "R8", "frame count", frames - f0, 2);
      chk(gap_err == 0 && rdy_err == 0, "R6", "back-to-back gap", gap_err, 0);
    end

    // R9: reset mid-frame
    issue(8'd3, 8'hb0, 2'd2, 16'h1717, 0);
    repeat (20) @(negedge clk);
    chk(cs_n == 0, "R9", "frame in flight", cs_n, 0);
    rst_n = 0;
    #1;
    chk(cs_n == 1 && sck == 1 && mosi == 0 && req_ready == 1 && done == 0,
        "R9", "async reset outputs", {cs_n, sck, mosi, req_ready, done}, 5'b11010);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    clr_err();
    issue(8'd1, 8'h10, 2'd0, 16'h0, 0);
    wait_done();
    chk(last_nb == 9 && last_frame[8:0] == 9'h010, "R9", "frame after reset",
        last_frame[8:0], 9'h010);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule